// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, once per clock, which of several hardware threads may place an instruction into a shared single-issue, in-order pipeline. Each thread keeps its own program counter inside the block. Per-thread stall causes arrive as level inputs: an outstanding cache miss, a pending trap or interrupt, a resource conflict, a long-latency next instruction, and a costly (second-level) miss. The block registers and presents the chosen thread number, that thread's PC and an issue-valid strobe. It also applies per-thread redirects and advances the PC of whichever thread issues.

A mode input picks the scheduling policy. In interleaved mode the selection rotates among ready threads every cycle. In blocked mode one thread keeps the pipeline until it suffers a costly miss. Selection then moves to the next ready thread and a one-cycle flush request is raised so that the pipeline is emptied and refilled.

Top module: `mt_thread_sel`

## Requirements
- R1: While `rst` is high at a clock edge, every PC is loaded with `RESET_VEC`, `issue_valid` and `flush` go low, `issue_tid` becomes 0, `issue_pc` becomes `RESET_VEC`, and thread 0 becomes the current (most recently issued) thread.
- R2: A thread t is ready when it is enabled and none of `stall_miss[t]`, `stall_trap[t]`, `stall_conflict[t]`, `long_lat[t]` and `costly_stall[t]` is set. Thread 0 is always enabled. Thread t>0 is enabled when `thr_enable[t]` is 1. Only a ready thread is ever issued.
- R3: With `coarse_mode`=0, the issued thread is the first ready thread found searching upward (modulo the thread count) from the thread after the current one. The issued thread becomes current. Outputs appear one clock after the inputs are sampled.
- R4: When no thread can be issued, `issue_valid` is 0 and the current thread is unchanged.
- R5: `issue_pc` equals the issued thread's stored PC. After issuing, that thread's PC grows by `INSTR_BYTES`.
- R6: `redirect_valid[t]`=1 loads `redirect_pc` slice t (bits t*PC_W upward) into thread t's PC. This takes priority over the issue increment.
- R7: With `coarse_mode`=1, the current thread is issued whenever it is ready. If it is not ready and its `costly_stall` is 0, nothing issues and the current thread is kept.
- R8: With `coarse_mode`=1, when the current thread has `costly_stall` set and another thread is ready, the thread is chosen by the search of R3 and issued. That thread becomes current, and `flush` is 1 for that one cycle.
- R9: With `coarse_mode`=1, when the current thread has `costly_stall` set and no other thread is ready, nothing issues, the current thread is kept and `flush` stays 0.
- R10: `flush` is never 1 for a cycle decided with `coarse_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_mode | input | 1 | 0 = interleave every cycle, 1 = switch on costly miss only |
| thr_enable | input | NTHREADS | Enables for threads 1 and up (bit 0 unused) |
| stall_miss | input | NTHREADS | Outstanding cache miss per thread |
| stall_trap | input | NTHREADS | Pending trap or interrupt per thread |
| stall_conflict | input | NTHREADS | Resource conflict per thread |
| long_lat | input | NTHREADS | Next instruction is long-latency, still busy |
| costly_stall | input | NTHREADS | Costly second-level miss per thread |
| redirect_valid | input | NTHREADS | Per-thread PC overwrite strobe |
| redirect_pc | input | NTHREADS*PC_W | Per-thread redirect targets, thread t at slice t |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | $clog2(NTHREADS) | Issued thread number |
| issue_pc | output | PC_W | PC of the issued thread |
| flush | output | 1 | One-cycle pipeline flush on a blocked-mode switch |

## Verification
The assertions take for granted that the stall, enable and mode inputs are stable around each rising edge. They also assume that a redirect to a thread is seen only through that thread's next issue. The bench drives every input just after the falling edge and holds it for a full cycle, and it compares outputs at the following falling edge. Redirect targets are random word-aligned values. Mode changes are applied on arbitrary cycles, so the check that the held thread stays put in blocked mode is exercised right after a switch out of interleaved mode.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE   = 2'd0,
    SEL_ISSUE  = 2'd1,
    SEL_SWITCH = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/mt_ready_mask.sv
module mt_ready_mask #(
  parameter int NTHREADS = 4
) (
  input  logic [NTHREADS-1:0] thr_enable,
  input  logic [NTHREADS-1:0] stall_miss,
  input  logic [NTHREADS-1:0] stall_trap,
  input  logic [NTHREADS-1:0] stall_conflict,
  input  logic [NTHREADS-1:0] long_lat,
  input  logic [NTHREADS-1:0] costly_stall,
  output logic [NTHREADS-1:0] ready
);
  genvar g;
  generate
    for (g = 0; g < NTHREADS; g++) begin : g_thr
      logic en;
      if (g == 0) begin : g_primary
        assign en = 1'b1;
      end else begin : g_other
        assign en = thr_enable[g];
      end
      assign ready[g] = en & ~(stall_miss[g] | stall_trap[g] | stall_conflict[g]
                               | long_lat[g] | costly_stall[g]);
    end
  endgenerate
endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int NTHREADS = 4,
  localparam int TID_W = $clog2(NTHREADS)
) (
  input  logic [NTHREADS-1:0] ready,
  input  logic [TID_W-1:0]    base,
  output logic                found,
  output logic [TID_W-1:0]    pick
);
  always_comb begin
    found = 1'b0;
    pick  = base;
    for (int i = 1; i <= NTHREADS; i++) begin
      int idx;
      idx = (int'(base) + i) % NTHREADS;
      if (!found && ready[idx]) begin
        found = 1'b1;
        pick  = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/mt_pc_file.sv
module mt_pc_file #(
  parameter int          NTHREADS    = 4,
  parameter int          PC_W        = 32,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_VEC   = 32'h0000_1000,
  localparam int TID_W = $clog2(NTHREADS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NTHREADS-1:0]      redirect_valid,
  input  logic [NTHREADS*PC_W-1:0] redirect_pc,
  input  logic                     adv_valid,
  input  logic [TID_W-1:0]         adv_tid,
  input  logic [TID_W-1:0]         rd_tid,
  output logic [PC_W-1:0]          rd_pc
);
  logic [NTHREADS*PC_W-1:0] pc_flat;

  genvar g;
  generate
    for (g = 0; g < NTHREADS; g++) begin : g_pc
      logic [PC_W-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pc_q <= PC_W'(RESET_VEC);
        end else if (redirect_valid[g]) begin
          pc_q <= redirect_pc[g*PC_W +: PC_W];
        end else if (adv_valid && (adv_tid == TID_W'(g))) begin
          pc_q <= pc_q + PC_W'(INSTR_BYTES);
        end
      end
      assign pc_flat[g*PC_W +: PC_W] = pc_q;
    end
  endgenerate

  assign rd_pc = pc_flat[rd_tid*PC_W +: PC_W];
endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel #(
  parameter int          NTHREADS    = 4,
  parameter int          PC_W        = 32,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_VEC   = 32'h0000_1000,
  localparam int TID_W = $clog2(NTHREADS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     coarse_mode,
  input  logic [NTHREADS-1:0]      thr_enable,
  input  logic [NTHREADS-1:0]      stall_miss,
  input  logic [NTHREADS-1:0]      stall_trap,
  input  logic [NTHREADS-1:0]      stall_conflict,
  input  logic [NTHREADS-1:0]      long_lat,
  input  logic [NTHREADS-1:0]      costly_stall,
  input  logic [NTHREADS-1:0]      redirect_valid,
  input  logic [NTHREADS*PC_W-1:0] redirect_pc,
  output logic                     issue_valid,
  output logic [TID_W-1:0]         issue_tid,
  output logic [PC_W-1:0]          issue_pc,
  output logic                     flush
);
  import mt_sel_pkg::*;

  logic [NTHREADS-1:0] ready;
  logic [TID_W-1:0]    cur_q;
  logic                rr_found;
  logic [TID_W-1:0]    rr_pick;
  sel_kind_e           kind;
  logic [TID_W-1:0]    next_tid;
  logic [PC_W-1:0]     sel_pc;
  logic                go;

  mt_ready_mask #(.NTHREADS(NTHREADS)) u_ready (
    .thr_enable    (thr_enable),
    .stall_miss    (stall_miss),
    .stall_trap    (stall_trap),
    .stall_conflict(stall_conflict),
    .long_lat      (long_lat),
    .costly_stall  (costly_stall),
    .ready         (ready)
  );

  mt_rr_pick #(.NTHREADS(NTHREADS)) u_pick (
    .ready(ready),
    .base (cur_q),
    .found(rr_found),
    .pick (rr_pick)
  );

  always_comb begin
    kind     = SEL_IDLE;
    next_tid = cur_q;
    if (!coarse_mode) begin
      if (rr_found) begin
        kind     = SEL_ISSUE;
        next_tid = rr_pick;
      end
    end else if (ready[cur_q]) begin
      kind     = SEL_ISSUE;
      next_tid = cur_q;
    end else if (costly_stall[cur_q] && rr_found) begin
      kind     = SEL_SWITCH;
      next_tid = rr_pick;
    end
  end

  assign go = (kind != SEL_IDLE);

  mt_pc_file #(
    .NTHREADS   (NTHREADS),
    .PC_W       (PC_W),
    .INSTR_BYTES(INSTR_BYTES),
    .RESET_VEC  (RESET_VEC)
  ) u_pcs (
    .clk           (clk),
    .rst           (rst),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .adv_valid     (go),
    .adv_tid       (next_tid),
    .rd_tid        (next_tid),
    .rd_pc         (sel_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= '0;
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      issue_pc    <= PC_W'(RESET_VEC);
      flush       <= 1'b0;
    end else begin
      issue_valid <= go;
      flush       <= (kind == SEL_SWITCH);
      if (go) begin
        cur_q     <= next_tid;
        issue_tid <= next_tid;
        issue_pc  <= sel_pc;
      end
    end
  end
endmodule

// File: rtl/mt_thread_sel_chk.sv
module mt_thread_sel_chk #(
  parameter int NTHREADS    = 4,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  localparam int TID_W = $clog2(NTHREADS)
) (
  input logic                clk,
  input logic                rst,
  input logic                coarse_mode,
  input logic [NTHREADS-1:0] thr_enable,
  input logic [NTHREADS-1:0] stall_miss,
  input logic [NTHREADS-1:0] stall_trap,
  input logic [NTHREADS-1:0] stall_conflict,
  input logic [NTHREADS-1:0] long_lat,
  input logic [NTHREADS-1:0] costly_stall,
  input logic [NTHREADS-1:0] redirect_valid,
  input logic                issue_valid,
  input logic [TID_W-1:0]    issue_tid,
  input logic [PC_W-1:0]     issue_pc,
  input logic                flush
);
  logic [NTHREADS-1:0] ok_now, ok_q, redir_q1, redir_q2;
  logic                coarse_q;

  assign ok_now = {thr_enable[NTHREADS-1:1], 1'b1}
                & ~(stall_miss | stall_trap | stall_conflict | long_lat | costly_stall);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q     <= '0;
      redir_q1 <= '0;
      redir_q2 <= '0;
      coarse_q <= 1'b0;
    end else begin
      ok_q     <= ok_now;
      redir_q1 <= redirect_valid;
      redir_q2 <= redir_q1;
      coarse_q <= coarse_mode;
    end
  end

  assert_ready_only_R2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ok_q[issue_tid]);

  assert_no_flush_fine_R10: assert property (@(posedge clk) disable iff (rst)
    flush |-> coarse_q);

  assert_flush_with_issue_R8: assert property (@(posedge clk) disable iff (rst)
    flush |-> issue_valid);

  assert_coarse_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (coarse_q && issue_valid && $past(issue_valid) && !flush)
      |-> (issue_tid == $past(issue_tid)));

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid) && (issue_tid == $past(issue_tid))
       && !redir_q2[issue_tid])
      |-> (issue_pc == $past(issue_pc) + PC_W'(INSTR_BYTES)));
endmodule

bind mt_thread_sel mt_thread_sel_chk #(
  .NTHREADS   (NTHREADS),
  .PC_W       (PC_W),
  .INSTR_BYTES(INSTR_BYTES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .coarse_mode   (coarse_mode),
  .thr_enable    (thr_enable),
  .stall_miss    (stall_miss),
  .stall_trap    (stall_trap),
  .stall_conflict(stall_conflict),
  .long_lat      (long_lat),
  .costly_stall  (costly_stall),
  .redirect_valid(redirect_valid),
  .issue_valid   (issue_valid),
  .issue_tid     (issue_tid),
  .issue_pc      (issue_pc),
  .flush         (flush)
);

// File: tb/mt_thread_sel_bench.sv
module mt_thread_sel_bench;
  localparam int          N   = 4;
  localparam int          PW  = 32;
  localparam int          IB  = 4;
  localparam logic [31:0] RV  = 32'h0000_1000;
  localparam int          TW  = $clog2(N);

  logic          clk = 1'b0;
  logic          rst;
  logic          coarse_mode;
  logic [N-1:0]  thr_enable, stall_miss, stall_trap, stall_conflict;
  logic [N-1:0]  long_lat, costly_stall, redirect_valid;
  logic [N*PW-1:0] redirect_pc;
  logic          issue_valid;
  logic [TW-1:0] issue_tid;
  logic [PW-1:0] issue_pc;
  logic          flush;

  int vectors = 0;
  int fails   = 0;

  // model state
  int          m_cur;
  logic [PW-1:0] m_pc [N];
  logic        e_valid, e_flush;
  int          e_tid;
  logic [PW-1:0] e_pc;
  string       e_tag;

  always #10 clk = ~clk;

  mt_thread_sel #(.NTHREADS(N), .PC_W(PW), .INSTR_BYTES(IB), .RESET_VEC(RV)) u_mt_thread_sel (
    .clk(clk), .rst(rst), .coarse_mode(coarse_mode), .thr_enable(thr_enable),
    .stall_miss(stall_miss), .stall_trap(stall_trap), .stall_conflict(stall_conflict),
    .long_lat(long_lat), .costly_stall(costly_stall), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .issue_valid(issue_valid), .issue_tid(issue_tid),
    .issue_pc(issue_pc), .flush(flush)
  );

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // R2: readiness from enables and stall causes
  function automatic logic rdy(int t);
    logic en;
    en = (t == 0) ? 1'b1 : thr_enable[t];
    return en & ~(stall_miss[t] | stall_trap[t] | stall_conflict[t] | long_lat[t] | costly_stall[t]);
  endfunction

  task automatic step();
    logic go, found;
    int   pick, nt;
    string kt;
    found = 1'b0; pick = m_cur;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = (m_cur + i) % N;
      if (!found && rdy(idx)) begin found = 1'b1; pick = idx; end
    end
    go = 1'b0; nt = m_cur; e_flush = 1'b0;
    if (!coarse_mode) begin
      kt = found ? "R3 R10" : "R4 R10";
      if (found) begin go = 1'b1; nt = pick; end
    end else if (rdy(m_cur)) begin
      kt = "R7"; go = 1'b1;
    end else if (costly_stall[m_cur] && found) begin
      kt = "R8"; go = 1'b1; nt = pick; e_flush = 1'b1;
    end else if (costly_stall[m_cur]) begin
      kt = "R9 R4";
    end else begin
      kt = "R7 R4";
    end
    e_valid = go;
    e_tid   = nt;
    e_pc    = m_pc[nt];
    e_tag   = $sformatf("%s R2 R5%s", kt, (redirect_valid != 0) ? " R6" : "");
    for (int t = 0; t < N; t++) begin
      if (redirect_valid[t]) m_pc[t] = redirect_pc[t*PW +: PW];
      else if (go && nt == t) m_pc[t] = m_pc[t] + PW'(IB);
    end
    if (go) m_cur = nt;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (issue_valid !== e_valid || issue_flush_bad() ||
        (e_valid && (int'(issue_tid) != e_tid || issue_pc !== e_pc))) begin
      fails++;
      $display("FAIL %s: valid/tid/pc/flush got %0d/%0d/%h/%0d expected %0d/%0d/%h/%0d",
               e_tag, issue_valid, issue_tid, issue_pc, flush, e_valid, e_tid, e_pc, e_flush);
    end
  endtask

  function automatic logic issue_flush_bad();
    return flush !== e_flush;
  endfunction

  task automatic clear_in();
    stall_miss = '0; stall_trap = '0; stall_conflict = '0;
    long_lat = '0; costly_stall = '0; redirect_valid = '0; redirect_pc = '0;
  endtask

  task automatic rand_in(int mode_sel);
    stall_miss     = N'($urandom) & N'($urandom);
    stall_trap     = N'($urandom) & N'($urandom) & N'($urandom);
    stall_conflict = N'($urandom) & N'($urandom) & N'($urandom);
    long_lat       = N'($urandom) & N'($urandom) & N'($urandom);
    costly_stall   = N'($urandom) & N'($urandom);
    redirect_valid = N'($urandom) & N'($urandom) & N'($urandom);
    for (int t = 0; t < N; t++) redirect_pc[t*PW +: PW] = $urandom & ~32'h3;
    if (($urandom % 64) == 0) thr_enable = N'($urandom);
    if (mode_sel == 2) coarse_mode = $urandom % 2;
    else coarse_mode = mode_sel[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1): actual still running, expected finished");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; coarse_mode = 1'b0; thr_enable = '1;
    clear_in();
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (issue_valid !== 1'b0 || flush !== 1'b0 || issue_tid !== '0 || issue_pc !== RV) begin
      fails++;
      $display("FAIL R1: valid/tid/pc/flush got %0d/%0d/%h/%0d expected 0/0/%h/0",
               issue_valid, issue_tid, issue_pc, flush, RV);
    end
    m_cur = 0;
    for (int t = 0; t < N; t++) m_pc[t] = RV;
    rst = 1'b0;
    // R3: all ready, fine mode: rotation 1,2,3,0,...
    for (int k = 0; k < 8; k++) step();
    // R4: nothing ready
    stall_miss = '1;
    for (int k = 0; k < 3; k++) step();
    // R2: only thread 2 ready via disables
    clear_in(); thr_enable = 4'b0100; stall_miss = 4'b0001;
    for (int k = 0; k < 3; k++) step();
    thr_enable = '1; clear_in();
    // R6: redirect on the thread that is about to issue
    redirect_valid = 4'b1111;
    for (int t = 0; t < N; t++) redirect_pc[t*PW +: PW] = 32'h0000_8000 + t * 32'h100;
    step();
    clear_in();
    for (int k = 0; k < 4; k++) step();
    // R7/R8/R9: coarse mode directed
    coarse_mode = 1'b1;
    for (int k = 0; k < 3; k++) step();
    stall_conflict = 4'b1111; step();           // R7 non-costly: hold
    clear_in(); costly_stall = 4'b1111; step(); // R9 no other ready
    clear_in(); costly_stall[m_cur] = 1'b1; step(); // R8 switch with flush
    clear_in(); step(); step();
    // near-exhaustive sweeps: fine, coarse, mixed
    for (int ph = 0; ph < 3; ph++) begin
      for (int k = 0; k < 3000; k++) begin
        rand_in(ph);
        step();
      end
    end
    report();
    $finish;
  end
endmodule